// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor

This block is a compact processor built around one accumulator. It runs a strict fetch, decode and execute loop, one instruction at a time, against a single memory that holds both code and data. Every memory access goes through an address-holding register and a word-holding buffer register. A fetched word moves from the buffer into an instruction register, and the control sequence decodes it there.

The instruction word is 8 bits wide. The upper nibble is the opcode and the lower nibble is either a memory address or an unsigned immediate. The memory port is synchronous: the word at the presented address appears on the read data input one clock later, and a write takes effect at the clock edge where the write enable is high. Software sees the result of a program through the memory contents, the three arithmetic flags and the halted output.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, flags and halted output. While reset is held, the memory address output is 0 and the write enable is low. The first instruction is fetched from address 0.
- R2: The opcode sits in bits 7:4 and the operand in bits 3:0. The codes are 0 halt, 1 load from memory, 2 store to memory, 3 load immediate, 4 add memory, 5 subtract memory, 6 add immediate, 7 subtract immediate, 8 AND memory, 9 OR memory, A jump if accumulator zero, B jump always. An immediate is zero-extended to 8 bits.
- R3: Each instruction takes a fixed number of cycles. Immediate, jump, halt and unused opcodes take 5, store takes 6, and instructions with a memory operand take 8. The program counter advances by one, wrapping at 16, during fetch and before execute.
- R4: Load from memory copies the addressed word into the accumulator, load immediate copies the operand, and store writes the accumulator to the addressed word.
- R5: Add and subtract, in both memory and immediate forms, wrap modulo 256 and update the flags {N,C,V} on sr_flags[2:0]. N is result bit 7. C is the unsigned carry out for add and the borrow for subtract. V is two's-complement overflow.
- R6: AND, OR, loads, stores, jumps and unused opcodes leave the flags unchanged.
- R7: Jump-if-zero loads the program counter with its operand only when the accumulator is zero. Jump-always always loads it.
- R8: Halt raises halted at the end of its 5th cycle. Halted stays high and no memory write occurs until reset.
- R9: Opcodes C to F act as 5-cycle no-ops.
- R10: A store drives the write enable high for exactly one cycle, with the address equal to the operand and the write data equal to the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 4 | Memory location, driven from the address register |
| mem_wdata | output | 8 | Write word, driven from the buffer register |
| mem_rdata | input | 8 | Read word, valid one cycle after the address |
| mem_we | output | 1 | Write enable |
| halted | output | 1 | High after a halt instruction until reset |
| sr_flags | output | 3 | Status flags {N,C,V} |

## Verification
The hardest case to reach from the ports is code that rewrites itself: a store lands on a word that is fetched later, or data words are executed as instructions. Loops that only end by wrapping the program counter are similarly hard to provoke. Random memory images of sixteen words produce these cases often, because every word is both a possible instruction and a possible operand. A bench model predicts the final memory image, flags and halt timing by stepping the same image instruction by instruction. Directed programs then pin down overflow, borrow, both outcomes of the conditional jump, and the unused opcodes.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W  = 4;
  localparam int FLAG_W = 3;

  localparam logic [OPC_W-1:0] OP_HALT = 4'h0;
  localparam logic [OPC_W-1:0] OP_LDM  = 4'h1;
  localparam logic [OPC_W-1:0] OP_STM  = 4'h2;
  localparam logic [OPC_W-1:0] OP_LDI  = 4'h3;
  localparam logic [OPC_W-1:0] OP_ADDM = 4'h4;
  localparam logic [OPC_W-1:0] OP_SUBM = 4'h5;
  localparam logic [OPC_W-1:0] OP_ADDI = 4'h6;
  localparam logic [OPC_W-1:0] OP_SUBI = 4'h7;
  localparam logic [OPC_W-1:0] OP_ANDM = 4'h8;
  localparam logic [OPC_W-1:0] OP_ORM  = 4'h9;
  localparam logic [OPC_W-1:0] OP_JZ   = 4'hA;
  localparam logic [OPC_W-1:0] OP_JMP  = 4'hB;

  typedef enum logic [3:0] {
    PH_FADR, PH_FRD, PH_FBUF, PH_DEC, PH_EXEC,
    PH_MRD, PH_MBUF, PH_MOP, PH_MWR, PH_HALT
  } phase_e;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int ARG_W  = 4,
  parameter int WORD_W = 8
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [ARG_W-1:0]  arg,
  output logic [WORD_W-1:0] result,
  output logic [FLAG_W-1:0] flags,
  output logic              flags_valid
);
  localparam int MSB = WORD_W - 1;

  // returns {N, C, V, value}
  function automatic logic [WORD_W+2:0] arith(input logic is_sub,
                                              input logic [WORD_W-1:0] a,
                                              input logic [WORD_W-1:0] b);
    logic [WORD_W:0]   ext;
    logic [WORD_W-1:0] val;
    logic              ov;
    ext = is_sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    val = ext[WORD_W-1:0];
    if (is_sub) ov = (a[MSB] != b[MSB]) && (val[MSB] != a[MSB]);
    else        ov = (a[MSB] == b[MSB]) && (val[MSB] != a[MSB]);
    return {val[MSB], ext[WORD_W], ov, val};
  endfunction

  logic [WORD_W-1:0] imm;
  logic [WORD_W+2:0] ar;
  logic              sub_sel;
  logic [WORD_W-1:0] operand;

  assign imm     = {{(WORD_W-ARG_W){1'b0}}, arg};
  assign sub_sel = (opc == OP_SUBM) || (opc == OP_SUBI);
  assign operand = ((opc == OP_ADDI) || (opc == OP_SUBI)) ? imm : mem_word;
  assign ar      = arith(sub_sel, acc, operand);

  always_comb begin
    flags_valid = 1'b0;
    case (opc)
      OP_LDM:                           result = mem_word;
      OP_LDI:                           result = imm;
      OP_ADDM, OP_SUBM, OP_ADDI, OP_SUBI: begin
        result      = ar[WORD_W-1:0];
        flags_valid = 1'b1;
      end
      OP_ANDM:                          result = acc & mem_word;
      OP_ORM:                           result = acc | mem_word;
      default:                          result = acc;
    endcase
  end

  assign flags = ar[WORD_W+2:WORD_W];
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  output phase_e           phase
);
  phase_e nxt;

  always_comb begin
    case (phase)
      PH_FADR: nxt = PH_FRD;
      PH_FRD:  nxt = PH_FBUF;
      PH_FBUF: nxt = PH_DEC;
      PH_DEC:  nxt = PH_EXEC;
      PH_EXEC: begin
        case (opc)
          OP_HALT:                          nxt = PH_HALT;
          OP_LDM, OP_ADDM, OP_SUBM,
          OP_ANDM, OP_ORM:                  nxt = PH_MRD;
          OP_STM:                           nxt = PH_MWR;
          default:                          nxt = PH_FADR;
        endcase
      end
      PH_MRD:  nxt = PH_MBUF;
      PH_MBUF: nxt = PH_MOP;
      PH_MOP:  nxt = PH_FADR;
      PH_MWR:  nxt = PH_FADR;
      PH_HALT: nxt = PH_HALT;
      default: nxt = PH_FADR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FADR;
    else     phase <= nxt;
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ARG_W = 4,
  localparam int WORD_W = OPC_W + ARG_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ARG_W-1:0]  mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic              halted,
  output logic [FLAG_W-1:0] sr_flags
);
  logic [ARG_W-1:0]  pc, mar;
  logic [WORD_W-1:0] mbr, cir, acc;
  logic [OPC_W-1:0]  opc;
  logic [ARG_W-1:0]  cir_arg;
  phase_e            phase;

  logic [WORD_W-1:0] alu_result;
  logic [FLAG_W-1:0] alu_flags;
  logic              alu_flags_valid;

  // named events for the checker
  logic ev_fetch, ev_imm_exec, ev_flag_wr, ev_jump, acc_zero;

  assign opc      = cir[WORD_W-1:ARG_W];
  assign cir_arg  = cir[ARG_W-1:0];
  assign acc_zero = (acc == '0);

  acc_cpu_seq seq_i (
    .clk   (clk),
    .rst   (rst),
    .opc   (opc),
    .phase (phase)
  );

  acc_cpu_alu #(.ARG_W(ARG_W), .WORD_W(WORD_W)) alu_i (
    .opc         (opc),
    .acc         (acc),
    .mem_word    (mbr),
    .arg         (cir_arg),
    .result      (alu_result),
    .flags       (alu_flags),
    .flags_valid (alu_flags_valid)
  );

  assign ev_fetch    = (phase == PH_FBUF);
  assign ev_imm_exec = (phase == PH_EXEC) &&
                       ((opc == OP_LDI) || (opc == OP_ADDI) || (opc == OP_SUBI));
  assign ev_flag_wr  = (ev_imm_exec || (phase == PH_MOP)) && alu_flags_valid;
  assign ev_jump     = (phase == PH_EXEC) &&
                       ((opc == OP_JMP) || ((opc == OP_JZ) && acc_zero));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      mar      <= '0;
      mbr      <= '0;
      cir      <= '0;
      acc      <= '0;
      sr_flags <= '0;
      halted   <= 1'b0;
    end else begin
      case (phase)
        PH_FADR: mar <= pc;
        PH_FBUF: begin
          mbr <= mem_rdata;
          pc  <= pc + {{(ARG_W-1){1'b0}}, 1'b1};
        end
        PH_DEC:  cir <= mbr;
        PH_EXEC: begin
          if (ev_imm_exec) acc <= alu_result;
          if (ev_flag_wr)  sr_flags <= alu_flags;
          if (ev_jump)     pc <= cir_arg;
          case (opc)
            OP_HALT: halted <= 1'b1;
            OP_STM: begin
              mar <= cir_arg;
              mbr <= acc;
            end
            OP_LDM, OP_ADDM, OP_SUBM, OP_ANDM, OP_ORM: mar <= cir_arg;
            default: ;
          endcase
        end
        PH_MBUF: mbr <= mem_rdata;
        PH_MOP: begin
          acc <= alu_result;
          if (ev_flag_wr) sr_flags <= alu_flags;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = (phase == PH_MWR);
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ARG_W  = 4,
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_fetch,
  input logic              ev_flag_wr,
  input logic              ev_jump,
  input logic [ARG_W-1:0]  pc,
  input logic [ARG_W-1:0]  cir_arg,
  input logic [WORD_W-1:0] acc,
  input logic [2:0]        sr_flags,
  input logic              halted,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_wdata
);
  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    ev_fetch |=> pc == ($past(pc) + {{(ARG_W-1){1'b0}}, 1'b1}));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_flag_wr |=> $stable(sr_flags));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    ev_jump |=> pc == $past(cir_arg));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R10
  store_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata == acc);
endmodule

bind acc_cpu acc_cpu_chk #(.ARG_W(ARG_W), .WORD_W(WORD_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ev_fetch   (ev_fetch),
  .ev_flag_wr (ev_flag_wr),
  .ev_jump    (ev_jump),
  .pc         (pc),
  .cir_arg    (cir_arg),
  .acc        (acc),
  .sr_flags   (sr_flags),
  .halted     (halted),
  .mem_we     (mem_we),
  .mem_wdata  (mem_wdata)
);

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic       mem_we;
  logic       halted;
  logic [2:0] sr_flags;

  always #4 clk = ~clk;

  acc_cpu dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .halted    (halted),
    .sr_flags  (sr_flags)
  );

  logic [7:0] img [16];
  logic [7:0] ram [16];
  logic       load_req = 1'b0;

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < 16; i++) ram[i] <= img[i];
    end else if (mem_we) begin
      ram[mem_addr] <= mem_wdata;
    end
    mem_rdata <= ram[mem_addr];
  end

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  logic [7:0] ref_mem [16];
  int r_acc, r_pc, r_flags;
  bit r_halt;

  // {N,C,V} then value, built from signed/unsigned integer sums
  function automatic int ref_arith(input int a, input int b, input bit sub, output int fl);
    int sa, sb, u, s, v;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    u = sub ? a - b : a + b;
    s = sub ? sa - sb : sa + sb;
    v = u & 255;
    fl = ((v >= 128) ? 4 : 0) + ((sub ? (u < 0) : (u > 255)) ? 2 : 0)
       + ((s > 127 || s < -128) ? 1 : 0);
    return v;
  endfunction

  task automatic ref_run(input int max_instr, output int cyc);
    int op, arg, w, fl;
    cyc = 0; r_acc = 0; r_pc = 0; r_flags = 0; r_halt = 0;
    for (int k = 0; k < max_instr && !r_halt; k++) begin
      w = ref_mem[r_pc]; op = w / 16; arg = w % 16;
      r_pc = (r_pc + 1) % 16;
      case (op)
        0: begin r_halt = 1; cyc += 5; end
        1: begin r_acc = ref_mem[arg]; cyc += 8; end
        2: begin ref_mem[arg] = r_acc[7:0]; cyc += 6; end
        3: begin r_acc = arg; cyc += 5; end
        4: begin r_acc = ref_arith(r_acc, ref_mem[arg], 0, fl); r_flags = fl; cyc += 8; end
        5: begin r_acc = ref_arith(r_acc, ref_mem[arg], 1, fl); r_flags = fl; cyc += 8; end
        6: begin r_acc = ref_arith(r_acc, arg, 0, fl); r_flags = fl; cyc += 5; end
        7: begin r_acc = ref_arith(r_acc, arg, 1, fl); r_flags = fl; cyc += 5; end
        8: begin r_acc = r_acc & ref_mem[arg]; cyc += 8; end
        9: begin r_acc = r_acc | ref_mem[arg]; cyc += 8; end
        10: begin if (r_acc == 0) r_pc = arg; cyc += 5; end
        11: begin r_pc = arg; cyc += 5; end
        default: cyc += 5;
      endcase
    end
  endtask

  task automatic reset_and_load();
    @(negedge clk);
    rst = 1'b1;
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_prog(input string tag, input int max_instr);
    int cyc;
    for (int i = 0; i < 16; i++) ref_mem[i] = img[i];
    ref_run(max_instr, cyc);
    reset_and_load();
    rst = 1'b0;
    if (r_halt) begin
      repeat (cyc - 1) @(posedge clk);
      @(negedge clk);
      check({tag, " R3/R8 halt not yet"}, halted, 0);
      @(posedge clk);
    end else begin
      repeat (cyc) @(posedge clk);
    end
    @(negedge clk);
    for (int i = 0; i < 16; i++)
      check($sformatf("%s R4/R5/R6/R7 mem[%0d]", tag, i), ram[i], ref_mem[i]);
    check({tag, " R5/R6 flags"}, sr_flags, r_flags);
    check({tag, " R8 halted"}, halted, r_halt);
  endtask

  task automatic clear_img(input logic [7:0] fill);
    for (int i = 0; i < 16; i++) img[i] = fill;
  endtask

  initial begin
    void'($urandom(32'h1d5e_0a77));
    clear_img(8'h00);
    reset_and_load();
    // R1 reset state
    check("R1 mem_addr", mem_addr, 0);
    check("R1 mem_we", mem_we, 0);
    check("R1 halted", halted, 0);
    check("R1 flags", sr_flags, 0);

    // R1 accumulator cleared: store it first
    clear_img(8'h00); img[15] = 8'h5A;
    img[0] = 8'h2F;
    run_prog("R1 acc", 4);
    check("R1 acc zero stored", ram[15], 8'h00);

    // R5 signed overflow: 0x7F + 1
    clear_img(8'h00); img[14] = 8'h7F;
    img[0] = 8'h1E; img[1] = 8'h61; img[2] = 8'h2F;
    run_prog("R5 ovf", 8);
    check("R5 ovf value", ram[15], 8'h80);
    check("R5 ovf flags NCV", sr_flags, 3'b101);

    // R5 borrow: 2 - 3
    clear_img(8'h00);
    img[0] = 8'h32; img[1] = 8'h73; img[2] = 8'h2F;
    run_prog("R5 borrow", 8);
    check("R5 borrow value", ram[15], 8'hFF);
    check("R5 borrow flags NCV", sr_flags, 3'b110);

    // R6 logic ops keep flags: borrow flags then AND/OR
    clear_img(8'h00); img[13] = 8'h3C; img[14] = 8'h0F;
    img[0] = 8'h70 | 8'h01; img[1] = 8'h8D; img[2] = 8'h9E; img[3] = 8'h2F;
    run_prog("R6 logic", 8);
    check("R6 and/or value", ram[15], 8'h3F);
    check("R6 flags kept", sr_flags, 3'b110);

    // R7 jump-if-zero taken: store skipped
    clear_img(8'h00); img[15] = 8'hAA;
    img[0] = 8'h30; img[1] = 8'hA4; img[2] = 8'h2F; img[3] = 8'h00;
    run_prog("R7 jz taken", 8);
    check("R7 taken skips store", ram[15], 8'hAA);

    // R7 jump-if-zero not taken
    clear_img(8'h00); img[15] = 8'hAA;
    img[0] = 8'h31; img[1] = 8'hA4; img[2] = 8'h2F; img[3] = 8'h00;
    run_prog("R7 jz not taken", 8);
    check("R7 not taken stores", ram[15], 8'h01);

    // R7 jump always, R2 encoding
    clear_img(8'h00); img[15] = 8'hAA;
    img[0] = 8'h39; img[1] = 8'hB5; img[2] = 8'h2F; img[5] = 8'h2E;
    run_prog("R2/R7 jmp", 8);
    check("R7 jmp skips", ram[15], 8'hAA);
    check("R2 ldi value", ram[14], 8'h09);

    // R9 unused opcodes act as no-ops
    clear_img(8'h00);
    img[0] = 8'h33; img[1] = 8'hC5; img[2] = 8'hFF; img[3] = 8'h2F;
    run_prog("R9 noop", 8);
    check("R9 acc kept", ram[15], 8'h03);

    // R8 halt is final: later words never run
    clear_img(8'h00); img[15] = 8'h11;
    img[0] = 8'h00; img[1] = 8'h2F;
    run_prog("R8 halt", 4);
    repeat (20) @(negedge clk);
    check("R8 stays halted", halted, 1);
    check("R8 no write after halt", ram[15], 8'h11);

    // random images, mixed code and data
    for (int p = 0; p < 60; p++) begin
      for (int i = 0; i < 16; i++) img[i] = 8'($urandom_range(0, 255));
      run_prog($sformatf("rand%0d", p), 25);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R8 run did not end actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule